// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This block works out, in the same cycle, where a 16-bit program counter goes next and which code address a table lookup reads. The fetch stage gives it the address of the instruction that follows the current one, and the decoder gives it a three-bit branch kind together with the opcode and the two operand bytes. The unit then returns the next PC and a taken flag. It handles page jumps, long jumps, signed relative jumps, jumps on carry set or clear, decrement-and-branch on a nonzero result, and compare-and-branch on inequality.

The same datapath produces three side results. The first is the decremented loop-register value, which is written back. The second is the carry produced by a compare. The third is the code address for an accumulator-plus-base table read, where the base is either the data pointer or the following-instruction address. The unit also returns the data pointer incremented by one. The block holds no state, and all address arithmetic wraps modulo 2^16.

Top module: `nxpc_unit`

## Requirements
- R1: With branch kind 1 (page jump), next_pc keeps bits 15:11 of seq_addr, takes bits 10:8 from opcode bits 7:5, and takes bits 7:0 from opnd_a. The low five opcode bits are 00001 for this kind. taken is 1.
- R2: With branch kind 2 (long jump), next_pc is {opnd_a, opnd_b}, with opnd_a as the high byte, and taken is 1.
- R3: With branch kind 3 (short jump), next_pc is seq_addr plus opnd_a read as a signed value from −128 to +127, modulo 2^16. taken is 1.
- R4: With branch kind 4, the jump is taken only when cy_in is 1. With branch kind 5, it is taken only when cy_in is 0. When taken, the target is seq_addr plus the signed opnd_a.
- R5: With branch kind 6, dec_val is dec_src minus one, and 00h wraps to FFh. The jump to seq_addr plus the signed opnd_a is taken only when dec_val is nonzero.
- R6: With branch kind 7, the jump is taken when cmp_lhs differs from cmp_rhs, and the target is seq_addr plus the signed opnd_b. For this kind, cy_out is 1 exactly when cmp_lhs is less than cmp_rhs, unsigned. For every other kind, cy_out equals cy_in.
- R7: tbl_addr is acc, zero-extended, plus a 16-bit base, modulo 2^16, with the low-byte carry reaching the high byte. The base is seq_addr when tbl_use_pc is 1 and dptr when it is 0.
- R8: dptr_inc is dptr plus one, modulo 2^16. A low byte of FFh rolls to 00h and increments the high byte.
- R9: With branch kind 0, and whenever a conditional jump is not taken, next_pc equals seq_addr and taken is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| seq_addr | input | 16 | Address of the following instruction |
| br_kind | input | 3 | Branch kind code (0 to 7, see requirements) |
| opcode | input | 8 | Current opcode; bits 7:5 give the page field |
| opnd_a | input | 8 | Second instruction byte |
| opnd_b | input | 8 | Third instruction byte |
| cy_in | input | 1 | Current carry flag |
| dec_src | input | 8 | Loop register value before the decrement |
| cmp_lhs | input | 8 | First compare operand |
| cmp_rhs | input | 8 | Second compare operand |
| acc | input | 8 | Accumulator |
| dptr | input | 16 | Data pointer |
| tbl_use_pc | input | 1 | Table base select: 1 for seq_addr, 0 for dptr |
| next_pc | output | 16 | Next program counter |
| taken | output | 1 | Branch taken |
| cy_out | output | 1 | Carry after the instruction |
| dec_val | output | 8 | Decremented loop register |
| tbl_addr | output | 16 | Table lookup code address |
| dptr_inc | output | 16 | Data pointer plus one |

## Verification
The hardest cases are the wrap corners, where a carry or borrow has to cross the byte boundary or the top of the 64K space. Examples are a backward offset from an address near zero, a forward offset near FFFFh, a table read from seq_addr FFFFh, and a page jump from an address whose bits 10:8 are all ones. Each of these comes from choosing seq_addr, dptr and the operand bytes directly, because the block is combinational. The decrement of 01h, which must fall through, and of 00h, which must branch, are driven through the same port values.

// File: rtl/nxpc_pkg.sv
package nxpc_pkg;
    typedef enum logic [2:0] {
        BR_NONE   = 3'd0,
        BR_PAGE   = 3'd1,
        BR_LONG   = 3'd2,
        BR_SHORT  = 3'd3,
        BR_IF_CY  = 3'd4,
        BR_IF_NCY = 3'd5,
        BR_DEC_NZ = 3'd6,
        BR_CMP_NE = 3'd7
    } br_kind_e;
endpackage

// File: rtl/nxpc_rel_add.sv
module nxpc_rel_add #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic [AW-1:0] base,
    input  logic [DW-1:0] offset,
    output logic [AW-1:0] sum
);
    localparam int EXT_W = AW - DW;
    logic [AW-1:0] off_ext;

    always_comb begin
        off_ext = {{EXT_W{offset[DW-1]}}, offset};
        sum     = base + off_ext;
    end

    always_comb begin
        if (offset[DW-1] == 1'b0)
            AST_FWD_NOT_BELOW: assert ((sum - base) < (AW'(1) << (DW-1))); // R3
    end
endmodule

// File: rtl/nxpc_addr_add.sv
module nxpc_addr_add #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic [AW-1:0] base,
    input  logic [DW-1:0] addend,
    output logic [AW-1:0] sum
);
    localparam int EXT_W = AW - DW;
    logic [AW-1:0] add_ext;

    always_comb begin
        add_ext = {{EXT_W{1'b0}}, addend};
        sum     = base + add_ext;
    end

    always_comb begin
        AST_DIFF_BOUNDED: assert ((sum - base) == add_ext); // R7
    end
endmodule

// File: rtl/nxpc_cond.sv
module nxpc_cond
    import nxpc_pkg::*;
#(
    parameter int DW = 8
) (
    input  br_kind_e      kind,
    input  logic          cy_in,
    input  logic [DW-1:0] dec_src,
    input  logic [DW-1:0] lhs,
    input  logic [DW-1:0] rhs,
    output logic          cond_ok,
    output logic [DW-1:0] dec_val,
    output logic          cy_out
);
    localparam logic [DW-1:0] ONE = DW'(1);

    always_comb begin
        dec_val = dec_src - ONE;
        cy_out  = cy_in;
        cond_ok = 1'b0;
        unique case (kind)
            BR_NONE:                     cond_ok = 1'b0;
            BR_PAGE, BR_LONG, BR_SHORT:  cond_ok = 1'b1;
            BR_IF_CY:                    cond_ok = cy_in;
            BR_IF_NCY:                   cond_ok = ~cy_in;
            BR_DEC_NZ:                   cond_ok = (dec_val != '0);
            BR_CMP_NE: begin
                cond_ok = (lhs != rhs);
                cy_out  = (lhs < rhs);
            end
            default:                     cond_ok = 1'b0;
        endcase
    end

    always_comb begin
        if (dec_src == '0)
            AST_DEC_WRAP: assert (dec_val == '1); // R5
        if (kind == BR_DEC_NZ && dec_src == ONE)
            AST_DEC_LAST_FALLS: assert (!cond_ok); // R5
        if (kind == BR_CMP_NE && lhs == rhs)
            AST_CMP_EQ_NO_CARRY: assert (!cond_ok && !cy_out); // R6
    end
endmodule

// File: rtl/nxpc_unit.sv
module nxpc_unit
    import nxpc_pkg::*;
#(
    parameter int AW     = 16,
    parameter int DW     = 8,
    parameter int PAGE_W = 3
) (
    input  logic [AW-1:0] seq_addr,
    input  logic [2:0]    br_kind,
    input  logic [DW-1:0] opcode,
    input  logic [DW-1:0] opnd_a,
    input  logic [DW-1:0] opnd_b,
    input  logic          cy_in,
    input  logic [DW-1:0] dec_src,
    input  logic [DW-1:0] cmp_lhs,
    input  logic [DW-1:0] cmp_rhs,
    input  logic [DW-1:0] acc,
    input  logic [AW-1:0] dptr,
    input  logic          tbl_use_pc,
    output logic [AW-1:0] next_pc,
    output logic          taken,
    output logic          cy_out,
    output logic [DW-1:0] dec_val,
    output logic [AW-1:0] tbl_addr,
    output logic [AW-1:0] dptr_inc
);
    localparam int SPLICE_W = DW + PAGE_W;
    localparam int KEEP_W   = AW - SPLICE_W;
    localparam int OPC_LO_W = DW - PAGE_W;
    localparam logic [OPC_LO_W-1:0] PAGE_OPC_LO = OPC_LO_W'(1);

    br_kind_e      kind_e;
    logic [DW-1:0] rel_off;
    logic [AW-1:0] rel_tgt;
    logic [AW-1:0] page_tgt;
    logic [AW-1:0] long_tgt;
    logic [AW-1:0] tgt;
    logic [AW-1:0] tbl_base;
    logic          cond_ok;

    assign kind_e = br_kind_e'(br_kind);

    // Operand byte that carries the relative offset
    always_comb begin
        rel_off = (kind_e == BR_CMP_NE) ? opnd_b : opnd_a;
    end

    nxpc_rel_add #(.AW(AW), .DW(DW)) u_rel (
        .base   (seq_addr),
        .offset (rel_off),
        .sum    (rel_tgt)
    );

    nxpc_cond #(.DW(DW)) u_cond (
        .kind    (kind_e),
        .cy_in   (cy_in),
        .dec_src (dec_src),
        .lhs     (cmp_lhs),
        .rhs     (cmp_rhs),
        .cond_ok (cond_ok),
        .dec_val (dec_val),
        .cy_out  (cy_out)
    );

    // Page splice and long target
    always_comb begin
        page_tgt = {seq_addr[AW-1 -: KEEP_W], opcode[DW-1 -: PAGE_W], opnd_a};
        long_tgt = AW'({opnd_a, opnd_b});
    end

    always_comb begin
        unique case (kind_e)
            BR_PAGE: tgt = page_tgt;
            BR_LONG: tgt = long_tgt;
            default: tgt = rel_tgt;
        endcase
        taken   = cond_ok;
        next_pc = cond_ok ? tgt : seq_addr;
    end

    // Table lookup and data pointer increment share one adder type
    always_comb begin
        tbl_base = tbl_use_pc ? seq_addr : dptr;
    end

    nxpc_addr_add #(.AW(AW), .DW(DW)) u_tbl (
        .base   (tbl_base),
        .addend (acc),
        .sum    (tbl_addr)
    );

    nxpc_addr_add #(.AW(AW), .DW(DW)) u_dpi (
        .base   (dptr),
        .addend (DW'(1)),
        .sum    (dptr_inc)
    );

    always_comb begin
        if (kind_e == BR_PAGE) begin
            AST_PAGE_KEEPS_TOP: assert (next_pc[AW-1 -: KEEP_W] == seq_addr[AW-1 -: KEEP_W]); // R1
            AST_PAGE_FORM: assert (opcode[OPC_LO_W-1:0] == PAGE_OPC_LO); // R1
        end
        if (kind_e == BR_LONG)
            AST_LONG_LOW_BYTE: assert (next_pc[DW-1:0] == opnd_b); // R2
        if (!taken)
            AST_FALL_THROUGH: assert (next_pc == seq_addr); // R9
        if (kind_e == BR_IF_CY && !cy_in)
            AST_CY_CLEAR_FALLS: assert (!taken); // R4
        AST_INC_MOVES: assert (dptr_inc != dptr); // R8
    end
endmodule

// File: tb/tb_nxpc_unit.sv
module tb_nxpc_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] seq_addr = '0;
    logic [2:0]  br_kind = '0;
    logic [7:0]  opcode = '0, opnd_a = '0, opnd_b = '0;
    logic        cy_in = 1'b0;
    logic [7:0]  dec_src = '0, cmp_lhs = '0, cmp_rhs = '0, acc = '0;
    logic [15:0] dptr = '0;
    logic        tbl_use_pc = 1'b0;
    logic [15:0] next_pc, tbl_addr, dptr_inc;
    logic        taken, cy_out;
    logic [7:0]  dec_val;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    nxpc_unit dut (
        .seq_addr(seq_addr), .br_kind(br_kind), .opcode(opcode),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .cy_in(cy_in),
        .dec_src(dec_src), .cmp_lhs(cmp_lhs), .cmp_rhs(cmp_rhs),
        .acc(acc), .dptr(dptr), .tbl_use_pc(tbl_use_pc),
        .next_pc(next_pc), .taken(taken), .cy_out(cy_out),
        .dec_val(dec_val), .tbl_addr(tbl_addr), .dptr_inc(dptr_inc)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] sx(input logic [7:0] b);
        return {{8{b[7]}}, b};
    endfunction

    task automatic settle();
        @(negedge clk);
        #2;
    endtask

    task automatic t_reset();
        settle();
        chk("R9 reset next_pc", next_pc, 16'h0000);
        chk("R9 reset taken", {15'd0, taken}, 16'd0);
    endtask

    task automatic t_page();
        br_kind = 3'd1; seq_addr = 16'h1234; opcode = 8'hA1; opnd_a = 8'h5C;
        settle();
        chk("R1 page5", next_pc, 16'h155C);
        chk("R1 taken", {15'd0, taken}, 16'd1);
        seq_addr = 16'hF7FF; opcode = 8'hE1; opnd_a = 8'h00;
        settle();
        chk("R1 page7 high block", next_pc, 16'hF700);
        seq_addr = 16'h8FFF; opcode = 8'h01; opnd_a = 8'hFF;
        settle();
        chk("R1 page0", next_pc, 16'h88FF);
    endtask

    task automatic t_long();
        br_kind = 3'd2; seq_addr = 16'h0003; opnd_a = 8'hAB; opnd_b = 8'hCD;
        settle();
        chk("R2 long", next_pc, 16'hABCD);
        chk("R2 taken", {15'd0, taken}, 16'd1);
    endtask

    task automatic t_short();
        br_kind = 3'd3;
        seq_addr = 16'h0100; opnd_a = 8'h80; settle();
        chk("R3 min offset", next_pc, 16'h0080);
        opnd_a = 8'h7F; settle();
        chk("R3 max offset", next_pc, 16'h017F);
        seq_addr = 16'hFFF0; opnd_a = 8'h20; settle();
        chk("R3 wrap up", next_pc, 16'h0010);
        seq_addr = 16'h0005; opnd_a = 8'hF0; settle();
        chk("R3 wrap down", next_pc, seq_addr + sx(8'hF0));
        cy_in = 1'b1; settle();
        chk("R6 carry passthrough", {15'd0, cy_out}, 16'd1);
        cy_in = 1'b0;
    endtask

    task automatic t_carry();
        seq_addr = 16'h0200; opnd_a = 8'h10;
        br_kind = 3'd4; cy_in = 1'b1; settle();
        chk("R4 jc taken", next_pc, 16'h0210);
        cy_in = 1'b0; settle();
        chk("R4 jc fall", next_pc, 16'h0200);
        chk("R9 jc not taken", {15'd0, taken}, 16'd0);
        br_kind = 3'd5; settle();
        chk("R4 jnc taken", next_pc, 16'h0210);
        cy_in = 1'b1; settle();
        chk("R4 jnc fall", next_pc, 16'h0200);
        cy_in = 1'b0;
    endtask

    task automatic t_dec();
        br_kind = 3'd6; seq_addr = 16'h0400; opnd_a = 8'hFC;
        dec_src = 8'h01; settle();
        chk("R5 dec to zero val", {8'd0, dec_val}, 16'h0000);
        chk("R5 dec to zero falls", next_pc, 16'h0400);
        dec_src = 8'h00; settle();
        chk("R5 wrap val", {8'd0, dec_val}, 16'h00FF);
        chk("R5 wrap branches", next_pc, 16'h03FC);
        dec_src = 8'h05; settle();
        chk("R5 nonzero branches", {15'd0, taken}, 16'd1);
    endtask

    task automatic t_cmp();
        br_kind = 3'd7; seq_addr = 16'h0500; opnd_a = 8'h77; opnd_b = 8'h04; cy_in = 1'b1;
        cmp_lhs = 8'h03; cmp_rhs = 8'h07; settle();
        chk("R6 less target", next_pc, 16'h0504);
        chk("R6 less carry", {15'd0, cy_out}, 16'd1);
        cmp_lhs = 8'h09; cmp_rhs = 8'h02; settle();
        chk("R6 greater carry", {15'd0, cy_out}, 16'd0);
        chk("R6 greater taken", {15'd0, taken}, 16'd1);
        cmp_lhs = 8'h42; cmp_rhs = 8'h42; settle();
        chk("R6 equal falls", next_pc, 16'h0500);
        chk("R6 equal carry", {15'd0, cy_out}, 16'd0);
        cy_in = 1'b0;
    endtask

    task automatic t_table();
        br_kind = 3'd0;
        acc = 8'hFF; dptr = 16'h12FE; tbl_use_pc = 1'b0; settle();
        chk("R7 dptr base carry", tbl_addr, 16'h13FD);
        tbl_use_pc = 1'b1; seq_addr = 16'hFFFF; acc = 8'h01; settle();
        chk("R7 pc base wrap", tbl_addr, 16'h0000);
        chk("R9 none fall", next_pc, 16'hFFFF);
    endtask

    task automatic t_dptr();
        dptr = 16'h12FF; settle();
        chk("R8 byte carry", dptr_inc, 16'h1300);
        dptr = 16'hFFFF; settle();
        chk("R8 wrap", dptr_inc, 16'h0000);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_reset();
        t_page();
        t_long();
        t_short();
        t_carry();
        t_dec();
        t_cmp();
        t_table();
        t_dptr();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule